// File: doc/BRIEF.md
# Daisy-Chainable Serial Angle Slave

This block is the serial readout side of an angle sensor. An external master drives a slow clock line; the slave samples that line with its own fast system clock. The first rising edge of the master clock, seen while the slave is idle, freezes the current angle and error flag. The slave then answers with a low acknowledge bit and a high start bit. After that it sends the angle MSB first, then the error bit, then an inverted 4-bit check code.

The check code is a CRC with generator x^4+x+1. Its register is preset from a per-device seed input, so a master can tell which chain member a frame came from. Once its own frame is complete, the slave routes its serial input to its serial output. A master that keeps clocking therefore reads every device in the chain as one long word. When the master clock stays still for a parameterised number of system clocks, the slave returns to idle and drives its output high. It can then freeze a new angle.

Top module: `angle_serial_slave`

## Requirements
- R1: After reset, and whenever the slave is idle, `sloOut` is 1.
- R2: The first synchronised rising edge of `maIn` in idle captures `posIn`, `errIn` and `crcSeed`. Later changes on these inputs do not alter the frame being sent.
- R3: After that capturing edge, `sloOut` is 0 (acknowledge) until the next rising edge of `maIn`.
- R4: The second rising edge drives `sloOut` to 1 (start bit) for one master period.
- R5: Rising edges 3 to 10 present the captured angle, bit 7 first and bit 0 last.
- R6: Rising edge 11 presents the captured error bit, with 1 meaning error.
- R7: Rising edges 12 to 15 present the bitwise inverse of the check code, bit 3 first. The check code is (seed·x^9 + m·x^4) mod (x^4+x+1). Here m is the 9-bit word {angle[7:0], error}, with angle bit 7 as the highest coefficient. This equals a 4-bit shift register preset to the seed that takes the 9 bits MSB first.
- R8: From rising edge 16 until the slave times out, `sloOut` equals `sliIn`, with no clock delay.
- R9: When the synchronised `maIn` has not changed for `TIMEOUT_CLKS` system clocks outside idle, the slave returns to idle. A rising edge before that moment continues the current sequence and captures nothing.
- R10: A timeout in the middle of a frame abandons that frame. The next rising edge starts a fresh acknowledge, start and data sequence with newly captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| maIn | input | 1 | Master serial clock, idle high, asynchronous to clk |
| sliIn | input | 1 | Serial data from the next device in the chain |
| posIn | input | POS_W | Current angle |
| errIn | input | 1 | Current error flag |
| crcSeed | input | 4 | Preset value of the check-code register |
| sloOut | output | 1 | Serial data toward the master |

## Verification
On every cycle, the assertions tie the output level to the sequencer phase: high in idle, low during acknowledge, high during the start bit, and equal to the chain input during pass-through. They also check that at most one datapath strobe fires at a time and that the bit counter stays inside the frame. Only the bench scenarios can show what the data bits carry. This covers the correct angle, error and inverted check code for every angle value and several seeds, freezing against input changes, the exact timeout window, continuation before the window ends, and a clean restart after an abandoned frame.

// File: rtl/angle_serial_pkg.sv
package angle_serial_pkg;
  localparam int CRC_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACK,
    PH_START,
    PH_DATA,
    PH_PASS
  } phase_t;

  typedef struct packed {
    logic load;
    logic startBit;
    logic shift;
    logic goIdle;
    logic passOn;
  } strobe_t;
endpackage

// File: rtl/angle_serial_ctrl.sv
module angle_serial_ctrl
  import angle_serial_pkg::*;
#(
  parameter int POS_W        = 8,
  parameter int TIMEOUT_CLKS = 5000,
  localparam int FRAME_W     = POS_W + 1 + CRC_W,
  localparam int CNT_W       = $clog2(FRAME_W + 1),
  localparam int TMO_W       = $clog2(TIMEOUT_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             maIn,
  output strobe_t          strb,
  output phase_t           phase,
  output logic [CNT_W-1:0] bitCnt
);
  logic maS1, maS2, maPrev;
  logic maRise, maEdge, timeoutHit;
  logic [TMO_W-1:0] idleCnt;
  phase_t nextPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maS1   <= 1'b1;
      maS2   <= 1'b1;
      maPrev <= 1'b1;
    end else begin
      maS1   <= maIn;
      maS2   <= maS1;
      maPrev <= maS2;
    end
  end

  assign maRise     = maS2 & ~maPrev;
  assign maEdge     = maS2 ^ maPrev;
  assign timeoutHit = (phase != PH_IDLE) && !maEdge &&
                      (idleCnt == TMO_W'(TIMEOUT_CLKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleCnt <= '0;
    else if (phase == PH_IDLE || maEdge || timeoutHit) idleCnt <= '0;
    else idleCnt <= idleCnt + 1'b1;
  end

  always_comb begin
    strb        = '0;
    strb.passOn = (phase == PH_PASS);
    nextPhase   = phase;
    if (timeoutHit) begin
      strb.goIdle = 1'b1;
      nextPhase   = PH_IDLE;
    end else if (maRise) begin
      unique case (phase)
        PH_IDLE: begin
          strb.load = 1'b1;
          nextPhase = PH_ACK;
        end
        PH_ACK: begin
          strb.startBit = 1'b1;
          nextPhase     = PH_START;
        end
        PH_START: begin
          strb.shift = 1'b1;
          nextPhase  = PH_DATA;
        end
        PH_DATA: begin
          if (bitCnt == CNT_W'(FRAME_W)) nextPhase = PH_PASS;
          else strb.shift = 1'b1;
        end
        default: nextPhase = phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
    end else begin
      phase <= nextPhase;
      if (strb.load) bitCnt <= '0;
      else if (strb.shift) bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/angle_serial_data.sv
module angle_serial_data
  import angle_serial_pkg::*;
#(
  parameter int         POS_W  = 8,
  parameter logic [3:0] POLY_LO = 4'h3,
  localparam int        FRAME_W = POS_W + 1 + CRC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [POS_W-1:0] posIn,
  input  logic             errIn,
  input  logic [CRC_W-1:0] crcSeed,
  input  logic             sliIn,
  output logic             sloOut
);
  logic [FRAME_W-1:0] frameReg;
  logic [CRC_W-1:0]   crcVal;
  logic               outBit;

  function automatic logic [CRC_W-1:0] calcCrc(
    input logic [POS_W:0]   msg,
    input logic [CRC_W-1:0] seed
  );
    logic [CRC_W-1:0] r;
    logic fb;
    r = seed;
    for (int i = POS_W; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ msg[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY_LO : '0);
    end
    return r;
  endfunction

  assign crcVal = calcCrc({posIn, errIn}, crcSeed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      outBit   <= 1'b1;
    end else if (strb.goIdle) begin
      outBit <= 1'b1;
    end else if (strb.load) begin
      frameReg <= {posIn, errIn, ~crcVal};
      outBit   <= 1'b0;
    end else if (strb.startBit) begin
      outBit <= 1'b1;
    end else if (strb.shift) begin
      outBit   <= frameReg[FRAME_W-1];
      frameReg <= {frameReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign sloOut = strb.passOn ? sliIn : outBit;
endmodule

// File: rtl/angle_serial_slave.sv
module angle_serial_slave
  import angle_serial_pkg::*;
#(
  parameter int POS_W        = 8,
  parameter int TIMEOUT_CLKS = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             maIn,
  input  logic             sliIn,
  input  logic [POS_W-1:0] posIn,
  input  logic             errIn,
  input  logic [3:0]       crcSeed,
  output logic             sloOut
);
  localparam int FRAME_W = POS_W + 1 + CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  strobe_t          strb;
  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;

  angle_serial_ctrl #(.POS_W(POS_W), .TIMEOUT_CLKS(TIMEOUT_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .maIn(maIn),
    .strb(strb), .phase(phase), .bitCnt(bitCnt)
  );

  angle_serial_data #(.POS_W(POS_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .posIn(posIn), .errIn(errIn), .crcSeed(crcSeed),
    .sliIn(sliIn), .sloOut(sloOut)
  );
endmodule

// File: rtl/angle_serial_checker.sv
module angle_serial_checker
  import angle_serial_pkg::*;
#(
  parameter int FRAME_W = 13,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sloOut,
  input logic             sliIn,
  input phase_t           phase,
  input strobe_t          strb,
  input logic [CNT_W-1:0] bitCnt
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_IDLE |-> sloOut);  // R1
  AST_ACK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_ACK |-> !sloOut);  // R3
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_START |-> sloOut);  // R4
  AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_PASS |-> sloOut == sliIn);  // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.startBit, strb.shift, strb.goIdle}));  // R9
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_W));  // R7
  AST_LOAD_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> phase == PH_ACK);  // R2
endmodule

bind angle_serial_slave angle_serial_checker #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .sloOut(sloOut), .sliIn(sliIn),
  .phase(phase), .strb(strb), .bitCnt(bitCnt)
);

// File: tb/tb_angle_serial_slave.sv
module tb_angle_serial_slave;
  localparam int TMO  = 64;
  localparam int HALF = 4;

  logic clk = 0, rstN = 0, maIn = 1, sliIn = 0, errIn = 0;
  logic [7:0] posIn = '0;
  logic [3:0] crcSeed = '0;
  logic sloOut;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  angle_serial_slave #(.POS_W(8), .TIMEOUT_CLKS(TMO)) dut (
    .clk(clk), .rstN(rstN), .maIn(maIn), .sliIn(sliIn),
    .posIn(posIn), .errIn(errIn), .crcSeed(crcSeed), .sloOut(sloOut)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (sloOut !== exp) begin
      errors++;
      $display("FAIL %s: sloOut=%b expected=%b at %0t", req, sloOut, exp, $time);
    end
  endtask

  task automatic waitClks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one master period: low half, then high half; ends just before the next fall
  task automatic maPulse();
    maIn = 0; waitClks(HALF);
    maIn = 1; waitClks(HALF);
  endtask

  // polynomial remainder of (seed*x^9 + msg*x^4) mod x^4+x+1
  function automatic logic [3:0] refCrc(input logic [8:0] msg, input logic [3:0] seed);
    logic [12:0] v;
    v = {4'b0, msg, 4'b0} ^ {seed, 9'b0};
    for (int i = 12; i >= 4; i--)
      if (v[i]) v = v ^ (13'h13 << (i - 4));
    return v[3:0];
  endfunction

  task automatic runFrame(input logic [7:0] p, input logic e, input logic [3:0] s);
    logic [3:0] c;
    c = refCrc({p, e}, s);
    posIn = p; errIn = e; crcSeed = s;
    maPulse(); check(1'b0, "R3 ack");
    posIn = ~p; errIn = ~e; crcSeed = ~s;  // R2: must not affect frame
    maPulse(); check(1'b1, "R4 start");
    for (int b = 7; b >= 0; b--) begin
      maPulse(); check(p[b], "R5 data/R2 frozen");
    end
    maPulse(); check(e, "R6 error bit");
    for (int b = 3; b >= 0; b--) begin
      maPulse(); check(~c[b], "R7 inverted crc");
    end
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitClks(3);
    check(1'b1, "R1 reset level");
    rstN = 1;
    waitClks(3);
    check(1'b1, "R1 idle level");

    for (int p = 0; p < 256; p++) begin
      logic [7:0] pv;
      pv = 8'(p);
      runFrame(pv, pv[0] ^ pv[5], pv[3:0] ^ pv[7:4]);
      sliIn = pv[1];
      maPulse(); #1; check(pv[1], "R8 pass-through");
      sliIn = ~pv[1]; #1; check(~pv[1], "R8 pass immediate");
      sliIn = 0;
      waitClks(TMO + 8);
      check(1'b1, "R9 timeout to idle");
    end

    // R9: rise before the window ends continues pass-through, no new capture
    runFrame(8'hA5, 1'b0, 4'h7);
    sliIn = 1;
    maPulse(); #1; check(1'b1, "R8 pass");
    waitClks(TMO / 2);
    maPulse(); #1; check(1'b1, "R9 continue not re-ack");
    sliIn = 0; #1; check(1'b0, "R9 still passing");
    waitClks(TMO - 8);
    check(1'b0, "R9 before window end");
    waitClks(16);
    check(1'b1, "R9 after window end");

    // R10: abandon a frame mid-data, then restart fresh
    posIn = 8'h3C; errIn = 1; crcSeed = 4'h2;
    maPulse(); maPulse(); maPulse(); maPulse();
    check(1'b0, "R10 mid-frame D6 of 3C");
    waitClks(TMO + 8);
    check(1'b1, "R10 idle after abort");
    runFrame(8'hC3, 1'b1, 4'h9);
    waitClks(TMO + 8);
    check(1'b1, "R1 idle at end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule